// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block is the status and interrupt register of a descriptor-driven DMA engine in a storage card host controller. The engine and the card logic send it one-cycle event pulses: transmit finished, receive finished, fatal bus fault, descriptor not available, and seven separate card error indications. Each pulse sets a sticky flag. The block also latches a 3-bit bus fault type code when the fault flag rises, and it shows the engine's present state code. It keeps two sticky summary bits, one normal and one abnormal. Each summary is fed only by the sources that a separate enable register lets through. The block drives one interrupt line.

Software uses a single register port with one select bit. Select 0 is the status word. Writing a 1 to a clearable bit of the status word clears that bit, and writing a 0 leaves it as it is. Select 1 is the source enable word, which is read/write. A write takes effect at the next clock edge. Read data is combinational from the stored state and the present state input.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, both the status word and the enable word read 0 and `irq` is 0.
- R2: A pulse on `ev_tx_done`, `ev_rx_done`, `ev_bus_fault` or `ev_desc_empty` sets status bit 0, 1, 2 or 4 respectively at the next clock edge.
- R3: A pulse on any bit of `card_err` sets status bit 5 (card error summary) at the next clock edge.
- R4: A write with `reg_sel`=0 clears each of status bits 0, 1, 2, 4, 5, 8 and 9 whose write-data bit is 1. Bits written with 0 keep their value.
- R5: If an event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R6: Status bit 8 (normal summary) is set whenever, after the write of this cycle, bit 0 is set with enable bit 0, or bit 1 is set with enable bit 1. It then stays set until it is written with 1.
- R7: Status bit 9 (abnormal summary) is set whenever, after the write of this cycle, bit 2 is set with enable bit 2, or bit 4 is set with enable bit 4. It then stays set until it is written with 1.
- R8: Status bits 12:10 load `bus_fault_code` only in the cycle in which bit 2 goes from 0 to 1. They hold while bit 2 stays set and read 0 whenever bit 2 is 0. They never affect `irq`.
- R9: Status bits 16:13 show `eng_state` directly.
- R10: Status bits 3, 7:6 and 31:17 always read 0. Writes to bits 3, 7:6 and 31:10 have no effect.
- R11: The enable word (`reg_sel`=1) stores write-data bits 0, 1, 2 and 4. All its other bits read 0.
- R12: `irq` is 1 exactly when status bit 8 or status bit 9 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx_done | input | 1 | Transmit completion pulse for one descriptor |
| ev_rx_done | input | 1 | Receive completion pulse for one descriptor |
| ev_bus_fault | input | 1 | Fatal bus fault pulse |
| bus_fault_code | input | 3 | Fault type that goes with `ev_bus_fault` (1: abort in transmit, 2: abort in receive) |
| ev_desc_empty | input | 1 | Descriptor-not-owned pulse |
| card_err | input | 7 | Card error indication pulses (end bit, response timeout, response CRC, start bit, read timeout, data CRC, response error) |
| eng_state | input | 4 | Present state code of the DMA engine |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the status word, 1 selects the enable word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Interrupt request |

## Verification
The collision that matters here is an event pulse and a write-one-to-clear hitting the same flag or summary in the same cycle. The bench provokes it in directed steps that pulse an event while writing all ones to the status word. It also makes it happen often in the random phase, where events and clearing writes are drawn independently each cycle. After each edge a bench model decides the outcome, with the set taking priority, and the model's status, enable and `irq` values are compared against the port values. Separate directed cases clear a summary while its source flag is still set and enabled, and re-raise the fault flag while it is already set, to confirm that the fault code is not loaded again.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  // Flag slots inside the internal flag vector
  localparam int FL_TX   = 0;
  localparam int FL_RX   = 1;
  localparam int FL_BUS  = 2;
  localparam int FL_DESC = 3;
  localparam int FL_CARD = 4;
  localparam int NUM_FLAGS = 5;

  // Bit positions inside the status word (software depends on these)
  localparam int POS_NORM_SUM = 8;
  localparam int POS_ABN_SUM  = 9;
  localparam int POS_CODE_LSB = 10;
  localparam int POS_STATE_LSB = 13;

  // Number of enable bits (one per interrupt-capable source)
  localparam int NUM_EN = 4;

  // Status word position of a flag slot
  function automatic int flag_pos(input int slot);
    case (slot)
      FL_TX:   return 0;
      FL_RX:   return 1;
      FL_BUS:  return 2;
      FL_DESC: return 4;
      default: return 5;
    endcase
  endfunction

  // Sticky update with set priority over clear
  function automatic logic sticky_next(input logic cur, input logic set_ev,
                                       input logic clr_req);
    return set_ev | (cur & ~clr_req);
  endfunction

  // True when a flag goes from clear to set
  function automatic logic rise_of(input logic cur, input logic nxt);
    return nxt & ~cur;
  endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import dma_irq_pkg::*;
#(
  parameter int N = NUM_FLAGS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] flag_d
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    assign flag_d[g] = sticky_next(flag_q[g], set_ev[g], clr_req[g]);

    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= flag_d[g];
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[g] |=> flag_q[g]);

    // R4
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[g] && !set_ev[g]) |=> !flag_q[g]);
  end

endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import dma_irq_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_d,
  input  logic [NSRC-1:0] src_en,
  input  logic            clr_req,
  output logic            sum_q,
  output logic            sum_set
);

  logic [NSRC-1:0] gated;
  assign gated   = src_d & src_en;
  assign sum_set = |gated;

  always_ff @(posedge clk) begin
    if (!rst_n) sum_q <= 1'b0;
    else        sum_q <= sticky_next(sum_q, sum_set, clr_req);
  end

  // R6 R7
  sum_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_q && !clr_req) |=> sum_q);

  // R6 R7
  sum_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_set |=> sum_q);

endmodule

// File: rtl/fault_code_latch.sv
module fault_code_latch
  import dma_irq_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_q,
  input  logic              fault_d,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q,
  output logic              capture
);

  assign capture = rise_of(fault_q, fault_d);

  always_ff @(posedge clk) begin
    if (!rst_n)        code_q <= '0;
    else if (capture)  code_q <= code_in;
    else if (!fault_d) code_q <= '0;
  end

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && fault_d) |=> $stable(code_q));

  // R8
  code_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_q |-> (code_q == '0));

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int STATE_W      = 4,
  parameter int CODE_W       = 3,
  parameter int NUM_CARD_ERR = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_tx_done,
  input  logic                    ev_rx_done,
  input  logic                    ev_bus_fault,
  input  logic [CODE_W-1:0]       bus_fault_code,
  input  logic                    ev_desc_empty,
  input  logic [NUM_CARD_ERR-1:0] card_err,
  input  logic [STATE_W-1:0]      eng_state,
  input  logic                    reg_wr,
  input  logic                    reg_sel,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic                    irq
);

  localparam int STATE_MSB = POS_STATE_LSB + STATE_W - 1;

  logic stat_wr, en_wr;
  assign stat_wr = reg_wr & ~reg_sel;
  assign en_wr   = reg_wr &  reg_sel;

  // Event and clear vectors, one slot per flag
  logic [NUM_FLAGS-1:0] ev_vec, clr_vec, flag_q, flag_d;
  assign ev_vec[FL_TX]   = ev_tx_done;
  assign ev_vec[FL_RX]   = ev_rx_done;
  assign ev_vec[FL_BUS]  = ev_bus_fault;
  assign ev_vec[FL_DESC] = ev_desc_empty;
  assign ev_vec[FL_CARD] = |card_err;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_clr
    assign clr_vec[g] = stat_wr & reg_wdata[flag_pos(g)];
  end

  irq_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (ev_vec),
    .clr_req (clr_vec),
    .flag_q  (flag_q),
    .flag_d  (flag_d)
  );

  // Source enable register: slots TX, RX, BUS, DESC
  logic [NUM_EN-1:0] en_q;
  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (en_wr) begin
      for (int i = 0; i < NUM_EN; i++) en_q[i] <= reg_wdata[flag_pos(i)];
    end
  end

  logic norm_q, abn_q, norm_set, abn_set;

  irq_summary #(.NSRC(2)) u_norm (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_d   ({flag_d[FL_RX], flag_d[FL_TX]}),
    .src_en  ({en_q[FL_RX], en_q[FL_TX]}),
    .clr_req (stat_wr & reg_wdata[POS_NORM_SUM]),
    .sum_q   (norm_q),
    .sum_set (norm_set)
  );

  irq_summary #(.NSRC(2)) u_abn (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_d   ({flag_d[FL_DESC], flag_d[FL_BUS]}),
    .src_en  ({en_q[FL_DESC], en_q[FL_BUS]}),
    .clr_req (stat_wr & reg_wdata[POS_ABN_SUM]),
    .sum_q   (abn_q),
    .sum_set (abn_set)
  );

  logic [CODE_W-1:0] code_q;
  logic              code_capture;

  fault_code_latch #(.CODE_W(CODE_W)) u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .fault_q (flag_q[FL_BUS]),
    .fault_d (flag_d[FL_BUS]),
    .code_in (bus_fault_code),
    .code_q  (code_q),
    .capture (code_capture)
  );

  // Read words
  logic [DATA_W-1:0] stat_word, en_word;
  always_comb begin
    stat_word = '0;
    for (int i = 0; i < NUM_FLAGS; i++) stat_word[flag_pos(i)] = flag_q[i];
    stat_word[POS_NORM_SUM] = norm_q;
    stat_word[POS_ABN_SUM]  = abn_q;
    stat_word[POS_CODE_LSB +: CODE_W] = code_q;
    stat_word[STATE_MSB -: STATE_W]   = eng_state;
  end

  always_comb begin
    en_word = '0;
    for (int i = 0; i < NUM_EN; i++) en_word[flag_pos(i)] = en_q[i];
  end

  assign reg_rdata = reg_sel ? en_word : stat_word;
  assign irq       = norm_q | abn_q;

  // R12
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_set || abn_set) |=> irq);

  // R8
  code_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_capture && !abn_set && !norm_set && !irq) |=> (irq == $past(norm_q | abn_q)));

endmodule

// File: tb/sim_dma_irq_status.sv
`timescale 1ns/1ps
module sim_dma_irq_status;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_tx, ev_rx, ev_bf, ev_du;
  logic [2:0]  bf_code;
  logic [6:0]  cerr;
  logic [3:0]  st;
  logic        wr, sel;
  logic [31:0] wd;
  logic [31:0] rd;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_irq_status u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_done(ev_tx), .ev_rx_done(ev_rx), .ev_bus_fault(ev_bf),
    .bus_fault_code(bf_code), .ev_desc_empty(ev_du), .card_err(cerr),
    .eng_state(st), .reg_wr(wr), .reg_sel(sel), .reg_wdata(wd),
    .reg_rdata(rd), .irq(irq)
  );

  // Bench model state
  logic m_ti, m_ri, m_fb, m_du, m_ce, m_ns, m_as;
  logic [2:0] m_code;
  logic [3:0] m_en; // order: tx, rx, fault, desc

  function automatic logic [31:0] exp_status(input logic [3:0] s);
    logic [31:0] w;
    w = 32'h0;
    w[0] = m_ti; w[1] = m_ri; w[2] = m_fb; w[4] = m_du; w[5] = m_ce;
    w[8] = m_ns; w[9] = m_as;
    w[12:10] = m_code;
    w[16:13] = s;
    return w;
  endfunction

  function automatic logic [31:0] exp_enable();
    return {27'h0, m_en[3], 1'b0, m_en[2:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_ti, m_ri, m_fb, m_du, m_ce, m_ns, m_as} = '0;
    m_code = '0; m_en = '0;
  endtask

  // Apply inputs for one edge and advance the model
  task automatic step(input logic t, input logic r, input logic f, input logic [2:0] c,
                      input logic d, input logic [6:0] ce, input logic [3:0] s,
                      input logic w, input logic sl, input logic [31:0] data);
    logic [31:0] clr;
    logic n_ti, n_ri, n_fb, n_du, n_ce;
    ev_tx = t; ev_rx = r; ev_bf = f; bf_code = c; ev_du = d; cerr = ce;
    st = s; wr = w; sel = sl; wd = data;
    @(posedge clk);
    clr = (w && !sl) ? data : 32'h0;
    n_ti = t | (m_ti & !clr[0]);
    n_ri = r | (m_ri & !clr[1]);
    n_fb = f | (m_fb & !clr[2]);
    n_du = d | (m_du & !clr[4]);
    n_ce = (ce != 0) | (m_ce & !clr[5]);
    if (!m_fb && n_fb) m_code = c;
    else if (!n_fb)    m_code = 3'b000;
    m_ns = (n_ti & m_en[0]) | (n_ri & m_en[1]) | (m_ns & !clr[8]);
    m_as = (n_fb & m_en[2]) | (n_du & m_en[3]) | (m_as & !clr[9]);
    m_ti = n_ti; m_ri = n_ri; m_fb = n_fb; m_du = n_du; m_ce = n_ce;
    if (w && sl) m_en = {data[4], data[2], data[1], data[0]};
    @(negedge clk);
    ev_tx = 0; ev_rx = 0; ev_bf = 0; ev_du = 0; cerr = '0; wr = 0;
  endtask

  task automatic observe(input string tag);
    sel = 0; #1;
    check({tag, " status"}, rd, exp_status(st));
    check({tag, " irq"}, {31'h0, irq}, {31'h0, m_ns | m_as});
    sel = 1; #1;
    check({tag, " enable"}, rd, exp_enable());
    sel = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; ev_tx = 0; ev_rx = 0; ev_bf = 0; ev_du = 0; bf_code = 0;
    cerr = 0; st = 0; wr = 0; sel = 0; wd = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    observe("R1 reset");

    // R2: each event sets its own bit; R3: card error lines one at a time
    step(1,0,0,0,0,0,4'h3,0,0,0); observe("R2 tx");
    step(0,1,0,0,0,0,4'h3,0,0,0); observe("R2 rx");
    step(0,0,0,0,1,0,4'h3,0,0,0); observe("R2 desc");
    for (int i = 0; i < 7; i++) begin
      step(0,0,0,0,0,7'(1 << i),4'h6,1,0,32'h20); observe("R3 card line");
    end
    // R4: clear with zeros leaves bits; clear with ones empties them
    step(0,0,0,0,0,0,4'h7,1,0,32'h0); observe("R4 zero write");
    step(0,0,0,0,0,0,4'h7,1,0,32'h0000_0013); observe("R4 w1c");
    // R11: enable register with reserved bits set in the write
    step(0,0,0,0,0,0,4'h1,1,1,32'hFFFF_FFFF); observe("R11 enable");
    // R6: tx with enable raises normal summary and irq (R12)
    step(1,0,0,0,0,0,4'h2,0,0,0); observe("R6 R12 normal");
    // R6: summary clear while source still set keeps summary
    step(0,0,0,0,0,0,4'h2,1,0,32'h100); observe("R6 held by source");
    step(0,0,0,0,0,0,4'h2,1,0,32'h101); observe("R6 clear both");
    // R8: fault with code 1, then second fault with code 2 must not reload
    step(0,0,1,3'b001,0,0,4'h4,0,0,0); observe("R7 R8 capture");
    step(0,0,1,3'b010,0,0,4'h4,0,0,0); observe("R8 no reload");
    // R10: writes to reserved and read-only fields
    step(0,0,0,0,0,0,4'h8,1,0,32'hFFFF_FCC8); observe("R10 reserved write");
    // R5: fault event collides with its clear; code held
    step(0,0,1,3'b010,0,0,4'h8,1,0,32'hFFFF_FFFF); observe("R5 collide");
    // R8: clearing the fault zeroes the code
    step(0,0,0,0,0,0,4'h8,1,0,32'h0000_0204); observe("R8 code clear");
    // R8: code with interrupts disabled gives no irq
    step(0,0,0,0,0,0,4'h0,1,1,32'h0); observe("R11 disable");
    step(0,0,1,3'b010,0,0,4'h0,0,0,0); observe("R8 no irq");
    step(0,0,0,0,0,0,4'h0,1,0,32'hFFFF_FFFF); observe("R4 clear all");
    // R9 via random state; random mix of events, writes and enables
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] data;
      logic w, sl;
      w = ($urandom_range(0, 2) == 0);
      sl = ($urandom_range(0, 4) == 0);
      data = $urandom();
      if ($urandom_range(0, 1) == 1) data = data | 32'h0000_0337;
      step($urandom_range(0,5)==0, $urandom_range(0,5)==0, $urandom_range(0,9)==0,
           3'($urandom_range(1,2)), $urandom_range(0,7)==0,
           ($urandom_range(0,7)==0) ? 7'($urandom()) : 7'h0,
           4'($urandom_range(0, 8)), w, sl, data);
      observe("R9 R5 R6 R7 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule